// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps one position count. The count can step on the system clock or can follow a two-phase incremental encoder wired to inputs A and B. A small synchronous register port sets the operating mode, starts and stops counting, and loads the count. It also programs a wrap-around ceiling, which can be buffered until software raises an update event. Software reads back the count, the last direction of travel and a sticky wrap flag through the same port.

In encoder modes both inputs pass through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one before it. Three decode options are available: count on A transitions only, on B transitions only, or on every transition of either input. In every option the phase relation between A and B sets the sign of each step. The count runs between zero and the active ceiling and wraps at both ends.

Top module: `qenc_counter`

## Requirements
- R1: After reset, the control register reads 0, the count reads 0, the status register reads 0, and the active ceiling and the buffered ceiling both read all ones.
- R2: When mode is 0 (control bits [3:2]) and the run bit (control bit 0) is 1, the count goes up by one on every clock.
- R3: In mode 1, each transition of A changes the count by one, and transitions of B are ignored. The count goes up when the new A level differs from the B level and goes down otherwise.
- R4: In mode 2, each transition of B changes the count by one, and transitions of A are ignored. The count goes up when the new B level equals the A level and goes down otherwise.
- R5: In mode 3, each transition of A or B changes the count by one, which gives four counts per encoder cycle. A leading B counts up. If A and B change in the same sample, nothing is counted.
- R6: Status bit 0 is 1 after a downward step and 0 after an upward step. Clock mode always steps upward.
- R7: An upward step from the ceiling or above goes to 0, and a downward step from 0 goes to the ceiling. Each wrap sets status bit 1. That bit stays set until 1 is written to status bit 1.
- R8: When the preload bit (control bit 1) is 0, a ceiling write (address 3) takes effect on the next clock.
- R9: When the preload bit is 1, a ceiling write changes only the buffered ceiling (address 4). Writing 1 to bit 0 of the event address (5) copies the buffered ceiling into the active ceiling. The event address always reads 0.
- R10: A write to the count register (address 2) loads the count, unless the value is above the active ceiling. Such a write is dropped.
- R11: While the run bit is 0, the count and the direction hold, and encoder transitions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | CNT_W | Register write data |
| bus_rdata_o | output | CNT_W | Register read data, combinational from address |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Direction of the last step, 1 means down |
| wrap_o | output | 1 | Sticky wrap flag |

## Verification
Register writes take effect on the clock edge that samples them and show on the read port from the next cycle. An encoder transition needs three edges to reach the count: two synchronizer flops, then the counter register. The bench holds each input level for four cycles before it moves on, so every step has landed before the next transition or read. In clock mode the bench counts the edges between the run write and the stop write exactly, because the stop edge still steps. Reads are queued at a falling edge and compared two nanoseconds after the next rising edge. At that point the combinational read path has settled and no write is in flight.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    MODE_CLK = 2'd0,
    MODE_EA  = 2'd1,
    MODE_EB  = 2'd2,
    MODE_EAB = 2'd3
  } qenc_mode_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT    = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CNT     = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_CEIL    = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_CEIL_SH = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_EVT     = 3'd5;

  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_PRE_BIT   = 1;
  localparam int CTRL_MODE_LSB  = 2;
  localparam int STAT_DIR_BIT   = 0;
  localparam int STAT_WRAP_BIT  = 1;
  localparam int EVT_UPD_BIT    = 0;
endpackage

// File: rtl/qenc_sync_edge.sv
module qenc_sync_edge #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] edge_o
);
  for (genvar g = 0; g < W; g++) begin : g_ch
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign edge_o[g] = chain_q[STAGES-1] ^ prev_q;
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  qenc_mode_e mode_i,
  input  logic [1:0] lvl_i,   // [0]=A, [1]=B
  input  logic [1:0] edge_i,
  output logic       step_o,
  output logic       up_o
);
  logic phase_diff;
  assign phase_diff = lvl_i[0] ^ lvl_i[1];

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (mode_i)
      MODE_CLK: begin
        step_o = 1'b1;
        up_o   = 1'b1;
      end
      MODE_EA: begin
        step_o = edge_i[0];
        up_o   = phase_diff;
      end
      MODE_EB: begin
        step_o = edge_i[1];
        up_o   = ~phase_diff;
      end
      MODE_EAB: begin
        // simultaneous change on both phases is not a legal step
        step_o = edge_i[0] ^ edge_i[1];
        up_o   = edge_i[0] ? phase_diff : ~phase_diff;
      end
      default: begin
        step_o = 1'b0;
        up_o   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              dir_i,
  input  logic              wrap_i,
  output logic              run_o,
  output logic              preload_o,
  output qenc_mode_e        mode_o,
  output logic [CNT_W-1:0]  ceil_o,
  output logic              cnt_wr_o,
  output logic              wrap_clr_o,
  output logic              upd_o
);
  logic             run_q, pre_q;
  qenc_mode_e       mode_q;
  logic [CNT_W-1:0] ceil_act_q, ceil_sh_q;
  logic             wr_ctrl, wr_ceil;

  assign wr_ctrl    = bus_we_i && (bus_addr_i == ADDR_CTRL);
  assign wr_ceil    = bus_we_i && (bus_addr_i == ADDR_CEIL);
  assign cnt_wr_o   = bus_we_i && (bus_addr_i == ADDR_CNT);
  assign wrap_clr_o = bus_we_i && (bus_addr_i == ADDR_STAT) && bus_wdata_i[STAT_WRAP_BIT];
  assign upd_o      = bus_we_i && (bus_addr_i == ADDR_EVT) && bus_wdata_i[EVT_UPD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pre_q  <= 1'b0;
      mode_q <= MODE_CLK;
    end else if (wr_ctrl) begin
      run_q  <= bus_wdata_i[CTRL_RUN_BIT];
      pre_q  <= bus_wdata_i[CTRL_PRE_BIT];
      mode_q <= qenc_mode_e'(bus_wdata_i[CTRL_MODE_LSB +: 2]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ceil_act_q <= '1;
      ceil_sh_q  <= '1;
    end else if (wr_ceil) begin
      ceil_sh_q <= bus_wdata_i;
      if (!pre_q) ceil_act_q <= bus_wdata_i;
    end else if (upd_o) begin
      ceil_act_q <= ceil_sh_q;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_CTRL: begin
        bus_rdata_o[CTRL_RUN_BIT]           = run_q;
        bus_rdata_o[CTRL_PRE_BIT]           = pre_q;
        bus_rdata_o[CTRL_MODE_LSB +: 2]     = mode_q;
      end
      ADDR_STAT: begin
        bus_rdata_o[STAT_DIR_BIT]  = dir_i;
        bus_rdata_o[STAT_WRAP_BIT] = wrap_i;
      end
      ADDR_CNT:     bus_rdata_o = count_i;
      ADDR_CEIL:    bus_rdata_o = ceil_act_q;
      ADDR_CEIL_SH: bus_rdata_o = ceil_sh_q;
      default:      bus_rdata_o = '0;
    endcase
  end

  assign run_o     = run_q;
  assign preload_o = pre_q;
  assign mode_o    = mode_q;
  assign ceil_o    = ceil_act_q;
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             wrap_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             dir_q, dir_nxt, wrap_q, wrap_hit;
  logic             load_ok;

  assign load_ok = cnt_wr_i && (cnt_wdata_i <= ceil_i);

  always_comb begin
    cnt_nxt  = cnt_q;
    dir_nxt  = dir_q;
    wrap_hit = 1'b0;
    if (load_ok) begin
      cnt_nxt = cnt_wdata_i;
    end else if (run_i && step_i) begin
      dir_nxt = ~up_i;
      if (up_i) begin
        if (cnt_q >= ceil_i) begin
          cnt_nxt  = '0;
          wrap_hit = 1'b1;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_nxt  = ceil_i;
          wrap_hit = 1'b1;
        end else begin
          cnt_nxt = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      dir_q  <= dir_nxt;
      wrap_q <= wrap_hit | (wrap_q & ~wrap_clr_i);
    end
  end

  assign count_o = cnt_q;
  assign dir_o   = dir_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_o,
  output logic              wrap_o
);
  logic [1:0]       enc_lvl, enc_edge;
  logic             step_w, up_w;
  logic             run_w, preload_w, cnt_wr_w, wrap_clr_w, upd_w;
  qenc_mode_e       mode_w;
  logic [CNT_W-1:0] ceil_w;

  qenc_sync_edge #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_b_i, enc_a_i}),
    .lvl_o  (enc_lvl),
    .edge_o (enc_edge)
  );

  qenc_decode u_dec (
    .mode_i (mode_w),
    .lvl_i  (enc_lvl),
    .edge_i (enc_edge),
    .step_o (step_w),
    .up_o   (up_w)
  );

  qenc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .count_i     (count_o),
    .dir_i       (dir_o),
    .wrap_i      (wrap_o),
    .run_o       (run_w),
    .preload_o   (preload_w),
    .mode_o      (mode_w),
    .ceil_o      (ceil_w),
    .cnt_wr_o    (cnt_wr_w),
    .wrap_clr_o  (wrap_clr_w),
    .upd_o       (upd_w)
  );

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_w),
    .step_i      (step_w),
    .up_i        (up_w),
    .ceil_i      (ceil_w),
    .cnt_wr_i    (cnt_wr_w),
    .cnt_wdata_i (bus_wdata_i),
    .wrap_clr_i  (wrap_clr_w),
    .count_o     (count_o),
    .dir_o       (dir_o),
    .wrap_o      (wrap_o)
  );
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              preload_i,
  input logic [1:0]        mode_i,
  input logic [CNT_W-1:0]  ceil_i,
  input logic              bus_we_i,
  input logic [REG_AW-1:0] bus_addr_i,
  input logic [CNT_W-1:0]  bus_wdata_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              dir_i,
  input logic              wrap_i
);
  logic cnt_wr;
  assign cnt_wr = bus_we_i && (bus_addr_i == ADDR_CNT);

  // R2
  clk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && mode_i == 2'd0 && !cnt_wr && count_i < ceil_i
    |=> count_i == CNT_W'($past(count_i) + 1'b1));

  // R6
  clk_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && mode_i == 2'd0 && !cnt_wr |=> !dir_i);

  // R7
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && mode_i == 2'd0 && !cnt_wr && count_i >= ceil_i
    |=> count_i == '0 && wrap_i);

  // R9
  preload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i && bus_we_i && bus_addr_i == ADDR_CEIL |=> $stable(ceil_i));

  // R10
  bad_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && cnt_wr && bus_wdata_i > ceil_i |=> $stable(count_i));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !cnt_wr |=> $stable(count_i) && $stable(dir_i));
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_w),
  .preload_i   (preload_w),
  .mode_i      (mode_w),
  .ceil_i      (ceil_w),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .count_i     (count_o),
  .dir_i       (dir_o),
  .wrap_i      (wrap_o)
);

// File: tb/qenc_counter_bench.sv
`timescale 1ns/1ps
module qenc_counter_bench;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enc_a = 1'b0, enc_b = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata, count;
  logic          dir, wrap;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [2:0]   q_addr[$];
  logic [W-1:0] q_exp[$];
  string        q_tag[$];

  always #4 clk = ~clk;

  qenc_counter u_qenc_counter (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .count_o(count), .dir_o(dir), .wrap_o(wrap)
  );

  // monitor: compares queued reads after the edge that follows the request
  always @(posedge clk) begin
    #2;
    if (q_exp.size() != 0) begin
      logic [2:0]   a;
      logic [W-1:0] e;
      string        t;
      a = q_addr.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_err++;
        $display("FAIL %s addr=%0d actual=%0h expected=%0h", t, a, rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [W-1:0] e, input string t);
    addr = a;
    q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic enc(input logic a, input logic b);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic fwd_cycle();
    enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
  endtask

  task automatic rev_cycle();
    enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(3'd0, 16'h0000, "R1 ctrl");
    chk(3'd2, 16'h0000, "R1 count");
    chk(3'd1, 16'h0000, "R1 status");
    chk(3'd3, 16'hFFFF, "R1 ceiling");
    chk(3'd4, 16'hFFFF, "R1 shadow");

    // R8 immediate ceiling, then clock mode run of 4 steps from 7
    wr(3'd3, 16'd9);
    chk(3'd3, 16'd9, "R8 ceiling immediate");
    wr(3'd2, 16'd7);
    wr(3'd0, 16'h0001);
    repeat (3) @(negedge clk);
    wr(3'd0, 16'h0000);
    chk(3'd2, 16'd1, "R2 clock count with wrap");
    chk(3'd1, 16'h0002, "R7 wrap flag set, R6 dir up");
    wr(3'd1, 16'h0002);
    chk(3'd1, 16'h0000, "R7 wrap flag cleared");

    // R10 out-of-range load dropped, in-range load taken
    wr(3'd2, 16'd20);
    chk(3'd2, 16'd1, "R10 load above ceiling ignored");
    wr(3'd2, 16'd4);
    chk(3'd2, 16'd4, "R10 load");

    // R9 preload + update event
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'd50);
    chk(3'd3, 16'd9, "R9 ceiling held while buffered");
    chk(3'd4, 16'd50, "R9 shadow written");
    wr(3'd5, 16'h0001);
    chk(3'd3, 16'd50, "R9 update event loads ceiling");
    chk(3'd5, 16'h0000, "R9 event reads zero");

    // R3 mode 1
    wr(3'd2, 16'd10);
    wr(3'd0, 16'h0007);
    fwd_cycle();
    chk(3'd2, 16'd12, "R3 A-edge forward");
    rev_cycle();
    chk(3'd2, 16'd10, "R3 A-edge reverse");
    chk(3'd1, 16'h0001, "R6 dir down");

    // R4 mode 2
    wr(3'd0, 16'h000B);
    fwd_cycle();
    chk(3'd2, 16'd12, "R4 B-edge forward");
    chk(3'd1, 16'h0000, "R6 dir up");

    // R5 mode 3
    wr(3'd0, 16'h000F);
    fwd_cycle();
    chk(3'd2, 16'd16, "R5 both-edge forward");
    rev_cycle();
    chk(3'd2, 16'd12, "R5 both-edge reverse");
    enc(1, 1);
    chk(3'd2, 16'd12, "R5 simultaneous change ignored");
    enc(0, 0);
    chk(3'd2, 16'd12, "R5 simultaneous return ignored");

    // R7 downward wrap
    wr(3'd2, 16'd0);
    enc(0, 1);
    chk(3'd2, 16'd50, "R7 down wrap to ceiling");
    chk(3'd1, 16'h0003, "R7 wrap flag and dir down");

    // R11 disabled: edges ignored
    wr(3'd0, 16'h000E);
    enc(1, 1); enc(1, 0); enc(0, 0);
    chk(3'd2, 16'd50, "R11 count held");
    chk(3'd1, 16'h0003, "R11 dir held");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule